// File: doc/BRIEF.md
# Cascadable Stereo Gain Serial Port

This block is the control-side receiver of a two-channel volume stage. A host drives three wires: an active-low select, a serial clock and a serial data line. While select is low, every rising serial-clock edge shifts one bit into a 16-bit register that holds an 8-bit gain code for the right channel followed by one for the left channel. When select returns high, the word is copied into the two gain registers and a single-cycle update strobe tells the gain logic that new codes are present.

The serial data output presents the most significant bit of the shift register and changes only after falling serial-clock edges, so it can feed the data input of an identical block. Several blocks therefore form one long shift path of 16 bits per block, with the select and clock shared. The first word sent ends in the block furthest down the chain. While select is high the output is released to high impedance.

The three serial inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and both serial-clock edges are found by comparing the synchronized level with its value one cycle earlier.

Top module: `gain_chain_port`

## Requirements
- R1: After reset both gain outputs are 0x00 and the update strobe is low.
- R2: A 16-bit transfer is taken most significant bit first. The first 8 bits form the right gain code (first bit = right bit 7), and the last 8 bits form the left gain code (last bit = left bit 0).
- R3: Bits are taken only on rising serial-clock edges while select is low. Serial-clock activity while select is high leaves the shift register unchanged.
- R4: On each rising edge of select, the shift register is copied to the gain outputs and the update strobe is high for exactly one system-clock cycle. At all other times the gain outputs hold their value.
- R5: The serial data output is high impedance whenever select is high.
- R6: While select is low, the serial data output shows the shift register's most significant bit. It is reloaded on the falling edge of select and after each falling serial-clock edge, so in a 16-bit transfer the output carries the word held before that transfer.
- R7: In a cascade of two blocks that share select and clock, with one block's output feeding the other's input, a 32-clock transfer leaves the first 16 bits in the downstream block and the last 16 bits in the upstream block.
- R8: If more than 16 bits are sent in one transfer, the block keeps the last 16 bits received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out to the next block, high impedance while deselected |
| gainRight | output | 8 | Right channel gain code |
| gainLeft | output | 8 | Left channel gain code |
| gainUpdate | output | 1 | One-cycle strobe marking newly loaded gain codes |

## Verification
The checks assume the serial clock runs no faster than a quarter of the system clock, so each synchronized level holds for at least two cycles. They also assume serial data is steady across each rising serial-clock edge and select changes only while the serial clock is low, never on the same cycle as a clock edge. The stimulus holds every serial-clock phase for four system cycles, changes data only in the low phase, and leaves four cycles between a select change and the nearest clock edge. A pull-up on the link net shows the released output during the high-impedance checks.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  typedef struct packed {
    logic shift;   // take one bit into the shift register
    logic emit;    // reload the outgoing bit from the register MSB
    logic commit;  // copy the word to the gain registers
  } strobe_t;
endpackage

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gsp_ctrl.sv
module gsp_ctrl
  import gsp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    sdi,
  output logic    sdiS,
  output strobe_t strobe
);
  logic csS, sclkS;
  logic csPrev, sclkPrev;
  logic riseEv, fallEv, csLow;

  gsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) csSync_i (
    .clk(clk), .rstN(rstN), .din(csN), .dout(csS));
  gsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) clkSync_i (
    .clk(clk), .rstN(rstN), .din(sclk), .dout(sclkS));
  gsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) datSync_i (
    .clk(clk), .rstN(rstN), .din(sdi), .dout(sdiS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  always_comb begin
    riseEv        = sclkS & ~sclkPrev;
    fallEv        = ~sclkS & sclkPrev;
    csLow         = ~csS;
    strobe.shift  = riseEv & csLow;
    strobe.emit   = (fallEv & csLow) | (csLow & csPrev);
    strobe.commit = csS & ~csPrev;
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shift, strobe.emit, strobe.commit}));

  // R4
  commit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !strobe.commit);

  // R3
  sclk_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseEv |=> !fallEv);
endmodule

// File: rtl/gsp_datapath.sv
module gsp_datapath
  import gsp_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int CHANNELS = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sdiS,
  input  strobe_t                    strobe,
  output logic                       sdoBit,
  output logic [CODE_W*CHANNELS-1:0] gainWord,
  output logic                       gainUpdate
);
  localparam int WORD_W = CODE_W * CHANNELS;

  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], sdiS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdoBit <= 1'b0;
    end else if (strobe.emit) begin
      sdoBit <= shiftReg[WORD_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainWord   <= '0;
      gainUpdate <= 1'b0;
    end else begin
      gainUpdate <= strobe.commit;
      if (strobe.commit) gainWord <= shiftReg;
    end
  end

  // R4
  update_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    gainUpdate |=> !gainUpdate);

  // R4
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(gainWord));

  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> $stable(shiftReg));

  // R6
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> $stable(sdoBit));
endmodule

// File: rtl/gain_chain_port.sv
module gain_chain_port
  import gsp_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output wire               sdo,
  output logic [CODE_W-1:0] gainRight,
  output logic [CODE_W-1:0] gainLeft,
  output logic              gainUpdate
);
  localparam int CHANNELS = 2;
  localparam int WORD_W   = CODE_W * CHANNELS;

  strobe_t           strobe;
  logic              sdiS;
  logic              sdoBit;
  logic [WORD_W-1:0] gainWord;

  gsp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdiS(sdiS), .strobe(strobe));

  gsp_datapath #(.CODE_W(CODE_W), .CHANNELS(CHANNELS)) data_i (
    .clk(clk), .rstN(rstN), .sdiS(sdiS), .strobe(strobe),
    .sdoBit(sdoBit), .gainWord(gainWord), .gainUpdate(gainUpdate));

  // right code is shifted in first, so it ends in the upper byte
  assign gainRight = gainWord[WORD_W-1:CODE_W];
  assign gainLeft  = gainWord[CODE_W-1:0];
  assign sdo       = csN ? 1'bz : sdoBit;
endmodule

// File: tb/gain_chain_port_tb_top.sv
module gain_chain_port_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, csN, sclk, sdi;
  wire  linkNet;
  wire  tailNet;
  pullup(linkNet);
  pulldown(tailNet);

  logic [7:0] gainRight, gainLeft, gainRight2, gainLeft2;
  logic       gainUpdate, gainUpdate2;

  gain_chain_port dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(linkNet), .gainRight(gainRight), .gainLeft(gainLeft),
    .gainUpdate(gainUpdate));

  gain_chain_port dut2_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(linkNet),
    .sdo(tailNet), .gainRight(gainRight2), .gainLeft(gainLeft2),
    .gainUpdate(gainUpdate2));

  int checks = 0;
  int fails  = 0;
  int updHigh = 0;
  bit done = 1'b0;

  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{16'h1234, 16'hFF00, 16'h00FF,
                                          16'hA55A, 16'h8001, 16'h7EC3};

  always @(negedge clk) if (gainUpdate) updHigh++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  logic [31:0] cap;
  logic        lastSdo;
  logic [7:0]  midRight, midLeft;

  task automatic xfer(input logic [31:0] bits, input int n);
    @(negedge clk) csN = 1'b0;
    repeat (4) @(negedge clk);
    cap = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (4) @(negedge clk);
      cap = {cap[30:0], linkNet};
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    lastSdo  = linkNet;
    midRight = gainRight;
    midLeft  = gainLeft;
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] prev;
    int u0;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(gainRight == 8'h00, "R1", "right after reset", gainRight, 0);
    check(gainLeft == 8'h00, "R1", "left after reset", gainLeft, 0);
    check(gainUpdate == 1'b0, "R1", "strobe after reset", gainUpdate, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(gainUpdate == 1'b0, "R1", "strobe idle", gainUpdate, 0);

    // vector table: R2, R4, R6
    prev = 16'h0000;
    for (int v = 0; v < NVEC; v++) begin
      u0 = updHigh;
      xfer({16'h0000, VEC[v]}, 16);
      check(gainRight == VEC[v][15:8], "R2", "right code", gainRight, VEC[v][15:8]);
      check(gainLeft == VEC[v][7:0], "R2", "left code", gainLeft, VEC[v][7:0]);
      check(updHigh - u0 == 1, "R4", "strobe cycles", updHigh - u0, 1);
      check(midRight == prev[15:8] && midLeft == prev[7:0], "R4",
            "gains held before select rise", {midRight, midLeft}, prev);
      check(cap[15:0] == prev, "R6", "sdo replays previous word", cap[15:0], prev);
      check(lastSdo == VEC[v][15], "R6", "sdo shows register MSB", lastSdo, VEC[v][15]);
      prev = VEC[v];
    end

    // R5: last word MSB is 0, released output reads the pull-up
    check(linkNet === 1'b1, "R5", "sdo released while deselected", linkNet, 1);

    // R3: clocks with select high are ignored
    for (int k = 0; k < 6; k++) begin
      sdi = k[0];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    check(gainRight == prev[15:8], "R3", "right untouched by stray clocks", gainRight, prev[15:8]);
    u0 = updHigh;
    xfer(32'h0, 0);
    check(gainRight == prev[15:8] && gainLeft == prev[7:0], "R3",
          "shift register untouched while deselected", {gainRight, gainLeft}, prev);
    check(updHigh - u0 == 1, "R4", "strobe on empty transfer", updHigh - u0, 1);

    // R8: overlong transfer keeps the last 16 bits
    xfer(32'h00ABCDEF, 24);
    check(gainRight == 8'hCD, "R8", "right after 24 bits", gainRight, 8'hCD);
    check(gainLeft == 8'hEF, "R8", "left after 24 bits", gainLeft, 8'hEF);

    // R7: two-block cascade
    xfer(32'h13579BDF, 32);
    check(gainRight == 8'h9B && gainLeft == 8'hDF, "R7", "upstream word",
          {gainRight, gainLeft}, 16'h9BDF);
    check(gainRight2 == 8'h13 && gainLeft2 == 8'h57, "R7", "downstream word",
          {gainRight2, gainLeft2}, 16'h1357);
    check(tailNet === 1'b0, "R5", "tail released while deselected", tailNet, 0);

    finish_run();
  end
endmodule